// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives a low-speed USB packet onto the D+/D- pair, holding each line state for a fixed number of clocks (8 by default). A one-cycle start pulse launches a packet. The block then takes the bus in the idle J state and sends a sync byte. After the sync byte come the payload bytes, which it fetches one at a time through a request strobe. It applies bit stuffing and NRZI coding, and finishes with an end-of-packet: two bit times of SE0, then one bit time of J. After that it releases the line drivers.

A short mode sends only a one-byte handshake PID, such as ACK, NAK or STALL, which is latched at the start pulse. In this mode no bytes are requested. The block also keeps the active device address. A pending address is adopted when a data packet completes, and is left untouched after a handshake. CRC generation, choosing the response and the receive path are left to the surrounding logic.

Top module: `ls_usb_tx`

## Requirements
- R1: After reset, oe_o, dp_o, dm_o, busy_o, done_o and byte_req_o are 0, and addr_o is 0.
- R2: A start_i pulse while idle enables the drivers from the next clock and holds J (dp_o=0, dm_o=1) for exactly one bit time before the first sync bit.
- R3: start_i is ignored while a packet is in progress; the waveform, the byte count and the packet type do not change.
- R4: The bits sent are the sync byte 0x80, then the packet bytes in order, each least significant bit first. Every line state lasts CLK_PER_BIT clocks. J is dp_o=0/dm_o=1, K is dp_o=1/dm_o=0, and both lines are never high together.
- R5: NRZI coding: a 0 bit toggles the line and a 1 bit keeps it. The line is J before the first bit.
- R6: After six consecutive 1 bits a stuffed toggle is inserted, including after the final payload bit. Any toggle clears the run count.
- R7: byte_req_o is a one-cycle strobe, and byte_i is taken in that same cycle. A data packet produces exactly len_i strobes, for len_i from 1 to 2**LEN_W-1.
- R8: With hs_i=1 the packet is sync plus hs_pid_i. len_i is ignored and byte_req_o stays low.
- R9: After the last bit (and any trailing stuff bit), the lines are SE0 for two bit times, then J for one bit time with the drivers on, then the drivers are off with both lines low.
- R10: done_o pulses for one clock, in the last clock of the closing J bit. In the next clock oe_o is 0.
- R11: addr_o takes new_addr_i on the done_o clock of a data packet only. It keeps its value during any packet and after a handshake.
- R12: busy_o is high from the clock after the accepted start until the clock after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle packet launch |
| hs_i | input | 1 | 1 = handshake packet, 0 = data packet |
| len_i | input | LEN_W | Number of payload bytes for a data packet |
| hs_pid_i | input | 8 | PID byte for a handshake packet |
| byte_i | input | 8 | Next payload byte, valid while byte_req_o is high |
| byte_req_o | output | 1 | Payload byte fetch strobe |
| new_addr_i | input | ADDR_W | Pending device address |
| addr_o | output | ADDR_W | Active device address |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | Packet finished, drivers released next clock |
| oe_o | output | 1 | Line driver enable |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |

## Verification
The bench sweeps data packets of one to four bytes with all-zero, all-one, alternating and ramp contents. It also sends a packet whose last byte ends in six ones, to force a trailing stuff bit. A design that skipped that bit, or that counted the run across a toggle, would start SE0 one bit early or late, or place a K where the bench expects a J. Handshake packets check that no byte is fetched and that the active address is kept, whereas a data packet must switch it exactly at done_o. A start pulse injected mid-packet with a different type must leave every following sampled bit and the final fetch count unchanged.

// File: rtl/ls_usb_tx_pkg.sv
package ls_usb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int unsigned SE0_BITS = 2;
endpackage

// File: rtl/ls_usb_tx_bit_timer.sv
module ls_usb_tx_bit_timer #(
  parameter int unsigned CLK_PER_BIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned TW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLK_PER_BIT - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ls_usb_tx_nrzi_stuffer.sv
module ls_usb_tx_nrzi_stuffer #(
  parameter int unsigned STUFF_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  logic bit_i,
  output logic line_o,   // 1 = J
  output logic stuff_o   // next step is a stuffed toggle
);
  localparam int unsigned OW = $clog2(STUFF_RUN + 1);

  logic [OW-1:0] ones_q;
  logic          line_q;

  assign line_o  = line_q;
  assign stuff_o = (ones_q == OW'(STUFF_RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      ones_q <= '0;
    end else if (load_i) begin
      line_q <= 1'b1;
      ones_q <= '0;
    end else if (step_i) begin
      if (stuff_o || !bit_i) begin
        line_q <= ~line_q;
        ones_q <= '0;
      end else begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import ls_usb_tx_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 8,
  parameter int unsigned STUFF_RUN   = 6,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned ADDR_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        hs_pid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_req_o,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              oe_o,
  output logic              dp_o,
  output logic              dm_o
);
  localparam logic [2:0] LAST_BIT = 3'd7;
  localparam logic [2:0] LAST_SE0 = 3'(SE0_BITS - 1);

  tx_state_e        state_q;
  logic [7:0]       sh_q;
  logic [2:0]       bit_idx_q;
  logic [LEN_W-1:0] left_q;
  logic             last_q;
  logic             hs_q;
  logic [7:0]       pid_q;
  logic [ADDR_W-1:0] addr_q;

  logic tick, step, consume, enc_step, enc_load, line, stuff;
  logic [7:0] next_byte;

  ls_usb_tx_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  assign step     = tick && (state_q == ST_PRE || state_q == ST_DATA);
  assign consume  = step && !stuff && !last_q;
  assign enc_step = step && (stuff || !last_q);
  assign enc_load = (state_q == ST_IDLE) && start_i;

  ls_usb_tx_nrzi_stuffer #(.STUFF_RUN(STUFF_RUN)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (enc_load),
    .step_i  (enc_step),
    .bit_i   (sh_q[0]),
    .line_o  (line),
    .stuff_o (stuff)
  );

  assign next_byte  = hs_q ? pid_q : byte_i;
  assign byte_req_o = consume && (bit_idx_q == LAST_BIT) && (left_q != '0) && !hs_q;
  assign done_o     = (state_q == ST_EOPJ) && tick;
  assign busy_o     = (state_q != ST_IDLE);
  assign addr_o     = addr_q;

  always_comb begin
    oe_o = 1'b1;
    dp_o = 1'b0;
    dm_o = 1'b1;
    unique case (state_q)
      ST_IDLE: begin oe_o = 1'b0; dm_o = 1'b0; end
      ST_SE0:  dm_o = 1'b0;
      ST_DATA: begin dp_o = ~line; dm_o = line; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      bit_idx_q <= '0;
      left_q    <= '0;
      last_q    <= 1'b0;
      hs_q      <= 1'b0;
      pid_q     <= '0;
      addr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_PRE;
          sh_q      <= SYNC_BYTE;
          bit_idx_q <= '0;
          left_q    <= hs_i ? LEN_W'(1) : len_i;
          last_q    <= 1'b0;
          hs_q      <= hs_i;
          pid_q     <= hs_pid_i;
        end
        ST_PRE, ST_DATA: if (tick) begin
          state_q <= ST_DATA;
          if (!stuff && last_q) begin
            state_q   <= ST_SE0;
            bit_idx_q <= '0;
          end else if (consume) begin
            if (bit_idx_q == LAST_BIT) begin
              bit_idx_q <= '0;
              if (left_q == '0) begin
                last_q <= 1'b1;
              end else begin
                sh_q   <= next_byte;
                left_q <= left_q - 1'b1;
              end
            end else begin
              sh_q      <= sh_q >> 1;
              bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
        end
        ST_SE0: if (tick) begin
          if (bit_idx_q == LAST_SE0) state_q <= ST_EOPJ;
          else                       bit_idx_q <= bit_idx_q + 1'b1;
        end
        ST_EOPJ: if (tick) begin
          state_q <= ST_IDLE;
          if (!hs_q) addr_q <= new_addr_i;  // address moves only after data packets
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ls_usb_tx_sva.sv
module ls_usb_tx_sva #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              byte_req_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              oe_o,
  input logic              dp_o,
  input logic              dm_o
);
  assert_no_se1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o && dm_o));

  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (!dp_o && !dm_o));

  assert_take_bus_j_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (oe_o && dm_o && !dp_o));

  assert_release_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!oe_o && !busy_o));

  assert_req_in_packet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> busy_o);

  assert_req_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |=> !byte_req_o);

  assert_addr_on_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o != $past(addr_o)) |-> $past(done_o));
endmodule

bind ls_usb_tx ls_usb_tx_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .byte_req_o (byte_req_o),
  .addr_o     (addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .oe_o       (oe_o),
  .dp_o       (dp_o),
  .dm_o       (dm_o)
);

// File: tb/ls_usb_tx_tb.sv
module ls_usb_tx_tb;
  localparam int LEN_W  = 4;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni;
  logic              start_i;
  logic              hs_i;
  logic [LEN_W-1:0]  len_i;
  logic [7:0]        hs_pid_i;
  logic [7:0]        byte_i;
  logic              byte_req_o;
  logic [ADDR_W-1:0] new_addr_i;
  logic [ADDR_W-1:0] addr_o;
  logic              busy_o, done_o, oe_o, dp_o, dm_o;

  ls_usb_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .hs_i(hs_i), .len_i(len_i),
    .hs_pid_i(hs_pid_i), .byte_i(byte_i), .byte_req_o(byte_req_o),
    .new_addr_i(new_addr_i), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
    .oe_o(oe_o), .dp_o(dp_o), .dm_o(dm_o)
  );

  logic [7:0] mem [8];
  int idx, nreq;
  int n_chk, n_fail;
  bit finished;
  int exp_line [256];
  int nbits;

  assign byte_i = mem[idx[2:0]];

  always @(posedge clk) begin
    if (start_i && !busy_o) begin
      idx  <= 0;
      nreq <= 0;
    end else if (byte_req_o) begin
      idx  <= idx + 1;
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input bit hs, input int len, input logic [7:0] pid);
    int line, ones, nb;
    logic [7:0] byt;
    line = 1; ones = 0; nbits = 0;
    nb = hs ? 1 : len;
    for (int j = 0; j <= nb; j++) begin
      byt = (j == 0) ? 8'h80 : (hs ? pid : mem[j-1]);
      for (int i = 0; i < 8; i++) begin
        if (!byt[i]) begin line = 1 - line; ones = 0; end
        else ones++;
        exp_line[nbits] = line; nbits++;
        if (ones == 6) begin
          line = 1 - line; ones = 0;
          exp_line[nbits] = line; nbits++;
        end
      end
    end
  endtask

  task automatic run_pkt(input bit hs, input int len, input logic [7:0] pid,
                         input logic [ADDR_W-1:0] na, input bit poke);
    logic [ADDR_W-1:0] old_addr;
    old_addr = addr_o;
    build(hs, len, pid);
    @(negedge clk);
    start_i = 1'b1; hs_i = hs; len_i = LEN_W'(len); hs_pid_i = pid; new_addr_i = na;
    @(posedge clk); #1 start_i = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk("R2 preamble oe", oe_o, 1);
    chk("R2 preamble J", {dp_o, dm_o}, 2'b01);
    chk("R12 busy", busy_o, 1);
    for (int k = 0; k < nbits; k++) begin
      repeat (8) begin @(posedge clk); #1 start_i = 1'b0; end
      #1;
      chk("R4 R5 R6 R3 line", {dp_o, dm_o}, exp_line[k] ? 2'b01 : 2'b10);
      if (k == 0) chk("R11 addr held", addr_o, old_addr);
      if (poke && k == 3) begin
        start_i = 1'b1; hs_i = ~hs; len_i = LEN_W'(len + 2);
      end
    end
    for (int s = 0; s < 2; s++) begin
      repeat (8) @(posedge clk);
      #2;
      chk("R9 se0", {oe_o, dp_o, dm_o}, 3'b100);
    end
    repeat (8) @(posedge clk);
    #2;
    chk("R9 closing J", {oe_o, dp_o, dm_o}, 3'b101);
    chk("R10 done early", done_o, 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R10 done pulse", done_o, 1);
    chk("R11 addr before done", addr_o, old_addr);
    @(posedge clk); #2;
    chk("R10 done single", done_o, 0);
    chk("R9 released", {oe_o, dp_o, dm_o}, 3'b000);
    chk("R12 idle", busy_o, 0);
    chk(hs ? "R8 no fetch" : "R7 fetch count", nreq, hs ? 0 : len);
    chk("R11 addr after", addr_o, hs ? old_addr : na);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_ni = 1'b0; start_i = 1'b0; hs_i = 1'b0; len_i = '0; hs_pid_i = '0;
    new_addr_i = '0;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset lines", {oe_o, dp_o, dm_o}, 3'b000);
    chk("R1 reset flags", {busy_o, done_o, byte_req_o}, 3'b000);
    chk("R1 reset addr", addr_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 idle after reset", {oe_o, busy_o}, 2'b00);

    for (int len = 1; len <= 4; len++) begin
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 8; i++)
          case (p)
            0: mem[i] = 8'h00;
            1: mem[i] = 8'hFF;
            2: mem[i] = (i % 2) ? 8'h5A : 8'hA5;
            default: mem[i] = 8'(8'h13 * (i + len));
          endcase
        run_pkt(1'b0, len, 8'h00, 7'(len * 4 + p + 1), 1'b0);
      end
    end
    // trailing stuff bit after the last payload bit (R6)
    mem[0] = 8'h3C; mem[1] = 8'hFC;
    run_pkt(1'b0, 2, 8'h00, 7'h55, 1'b0);
    // handshakes keep the address (R8, R11)
    run_pkt(1'b1, 9, 8'hD2, 7'h2A, 1'b0);
    run_pkt(1'b1, 0, 8'h5A, 7'h11, 1'b0);
    run_pkt(1'b1, 3, 8'h1E, 7'h7F, 1'b0);
    // start while busy is ignored (R3)
    mem[0] = 8'hC3; mem[1] = 8'h81; mem[2] = 8'hFF;
    run_pkt(1'b0, 3, 8'h00, 7'h66, 1'b1);
    run_pkt(1'b1, 2, 8'hD2, 7'h01, 1'b1);
    finish_run();
  end
endmodule